// File: doc/BRIEF.md
# Credit-Gated Posted Write Packetizer

This block copies a run of dwords from a local memory into host memory as a series of posted write requests. A single start command supplies the local source address, the host destination byte address and the length in dwords. The block cuts the run into packets, puts a three-dword write header in front of each one, and sends header and payload as one stream of dword beats with ready/valid flow control.

Packet size is set at run time by a payload-size code in the device control word, which is limited by a capability code and by the largest payload the block supports (256 bytes). No packet crosses a 4 KB host page, and the last packet carries whatever remains. Before the block commits a packet, it checks the link partner's credit limits. It needs one header credit and one data credit per 16 bytes of payload. Available credit is the partner's limit minus the block's consumed count, taken modulo the counter width. Consumed credit comes back only when the partner raises its limits, and until then the block waits.

Top module: `pw_packetizer`

## Requirements
- R1: Each packet's length in dwords is the smallest of the remaining length, the effective payload size and the dwords left before the next 4 KB host boundary.
- R2: Size codes mean 0 = 128 B, 1 = 256 B, 2 = 512 B and so on. The effective code is the smaller of `ctl_mps` and `cap_mps`, capped at code 1 (256 B = 64 dwords).
- R3: No packet's host byte range crosses a 4 KB boundary.
- R4: A header is three beats. Beat 0 has bits [31:24] = 0x40 and bits [9:0] = the packet length in dwords, with all other bits 0. Beat 1 has bits [3:0] = 0xF, bits [7:4] = 0xF (or 0x0 when the length is 1), and all other bits 0. Beat 2 carries the destination byte address with bits [1:0] = 0.
- R5: Payload beat i of the whole command is local word `cmd_src + i`. `tx_sop` marks header beat 0 only, and `tx_eop` marks the last payload beat only.
- R6: A packet is committed only when (`hdr_limit` − header used) mod 2^HDR_CW ≥ 1 and (`dat_limit` − data used) mod 2^DAT_CW ≥ ceil(len/4). Committing adds 1 and ceil(len/4) to the used counters.
- R7: While either credit is short, no beat is sent and `busy` stays high. Sending resumes once the limits are raised far enough.
- R8: Used counters and the available-credit arithmetic wrap modulo their widths, with no loss of packets.
- R9: A beat offered while `tx_ready` is low is held unchanged until it is accepted.
- R10: `done` is a one-cycle pulse in the cycle after the last payload beat is accepted. `busy` is high from the cycle after a start until that pulse. After reset, `busy`, `done` and `tx_valid` are low.
- R11: A start while busy is ignored. A start with length 0 sends no beats and pulses `done` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start command strobe |
| cmd_src | input | LOC_AW | Local source word address |
| cmd_dst | input | 32 | Host destination byte address (dword aligned) |
| cmd_len | input | LEN_W | Length in dwords |
| ctl_mps | input | 3 | Payload size code in use |
| cap_mps | input | 3 | Payload size capability code |
| hdr_limit | input | HDR_CW | Header credit limit from the link partner |
| dat_limit | input | DAT_CW | Data credit limit from the link partner |
| rd_en | output | 1 | Local memory read enable |
| rd_addr | output | LOC_AW | Local memory read address |
| rd_data | input | 32 | Local memory data, one cycle after `rd_en` |
| tx_valid | output | 1 | Output beat valid |
| tx_ready | input | 1 | Downstream accepts the beat |
| tx_data | output | 32 | Header or payload dword |
| tx_sop | output | 1 | First header beat |
| tx_eop | output | 1 | Last payload beat |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished pulse |

## Verification
Assertions check on every cycle that a packet is committed only with enough header and data credit, that a committed packet fits within its 4 KB page, that used counters step modulo their width, that header length fields stay within the payload cap, that a held beat stays stable, and that `done` is a single pulse seen while idle. The correctness of header fields, payload order, the choice among the remaining length, the size code and the page boundary, the stall at exact credit boundaries, and the handling of ignored or zero-length starts can only be shown by the bench's scenarios against its reference model.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int HDR_BEATS = 3;
  localparam int PAGE_DW   = 1024;

  typedef enum logic [2:0] {
    S_IDLE, S_SIZE, S_GATE, S_HDR, S_PAY, S_DRAIN
  } pw_state_t;

  function automatic logic [31:0] hdr_word(input logic [1:0] idx,
                                           input logic [9:0] len,
                                           input logic [29:0] dst_dw);
    logic [31:0] w;
    case (idx)
      2'd0:    w = {8'h40, 14'h0, len};
      2'd1:    w = {24'h0, (len == 10'd1) ? 4'h0 : 4'hF, 4'hF};
      default: w = {dst_dw, 2'b00};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/pw_size_calc.sv
module pw_size_calc #(
  parameter int LEN_W    = 13,
  parameter int MAX_CODE = 1
) (
  input  logic [2:0]       ctl_code,
  input  logic [2:0]       cap_code,
  input  logic [LEN_W-1:0] remain,
  input  logic [9:0]       page_off,
  output logic [LEN_W-1:0] pkt_len
);
  localparam logic [2:0] MAXC = 3'(MAX_CODE);

  logic [2:0]       eff;
  logic [LEN_W-1:0] mps_dw;
  logic [LEN_W-1:0] page_left;
  logic [LEN_W-1:0] m1;

  always_comb begin
    eff = (ctl_code < cap_code) ? ctl_code : cap_code;
    if (eff > MAXC) eff = MAXC;
    mps_dw    = LEN_W'(32) << eff;
    page_left = LEN_W'(11'd1024 - {1'b0, page_off});
    m1        = (remain < mps_dw) ? remain : mps_dw;
    pkt_len   = (m1 < page_left) ? m1 : page_left;
  end
endmodule

// File: rtl/pw_credit_gate.sv
module pw_credit_gate #(
  parameter int HDR_CW = 6,
  parameter int DAT_CW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HDR_CW-1:0] hdr_limit,
  input  logic [DAT_CW-1:0] dat_limit,
  input  logic [DAT_CW-1:0] need_dat,
  input  logic              take,
  output logic              ok,
  output logic [HDR_CW-1:0] hdr_used,
  output logic [DAT_CW-1:0] dat_used
);
  logic [HDR_CW-1:0] hdr_av;
  logic [DAT_CW-1:0] dat_av;

  always_comb begin
    hdr_av = hdr_limit - hdr_used;
    dat_av = dat_limit - dat_used;
    ok     = (hdr_av != '0) && (dat_av >= need_dat);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_used <= '0;
      dat_used <= '0;
    end else if (take) begin
      hdr_used <= hdr_used + HDR_CW'(1);
      dat_used <= dat_used + need_dat;
    end
  end
endmodule

// File: rtl/pw_prefetch.sv
module pw_prefetch #(
  parameter int DW    = 32,
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [DW-1:0]              head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  assign head = mem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + PW'(1);
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/pw_packetizer.sv
module pw_packetizer
  import pw_pkg::*;
#(
  parameter int LOC_AW   = 10,
  parameter int LEN_W    = 13,
  parameter int HDR_CW   = 6,
  parameter int DAT_CW   = 8,
  parameter int MAX_CODE = 1,
  parameter int PF_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LOC_AW-1:0] cmd_src,
  input  logic [31:0]       cmd_dst,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [2:0]        ctl_mps,
  input  logic [2:0]        cap_mps,
  input  logic [HDR_CW-1:0] hdr_limit,
  input  logic [DAT_CW-1:0] dat_limit,
  output logic              rd_en,
  output logic [LOC_AW-1:0] rd_addr,
  input  logic [31:0]       rd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = $clog2(PF_DEPTH+1);
  localparam int OCC_W = CNT_W + 1;

  pw_state_t         state;
  logic [LOC_AW-1:0] src_q;
  logic [29:0]       dst_q;
  logic [29:0]       pkt_dst;
  logic [LEN_W-1:0]  rem_q, pkt_len_q, rd_left, pay_left;
  logic [1:0]        hdr_idx;
  logic              rd_pend;

  logic [LEN_W-1:0]  calc_len;
  logic [DAT_CW-1:0] need_dat;
  logic              gate_ok, commit;
  logic [HDR_CW-1:0] hdr_used;
  logic [DAT_CW-1:0] dat_used;
  logic [31:0]       pf_head;
  logic [CNT_W-1:0]  pf_cnt;
  logic              pf_pop, tx_free;
  logic [OCC_W-1:0]  occ;

  pw_size_calc #(.LEN_W(LEN_W), .MAX_CODE(MAX_CODE)) u_size (
    .ctl_code(ctl_mps), .cap_code(cap_mps), .remain(rem_q),
    .page_off(dst_q[9:0]), .pkt_len(calc_len)
  );

  assign need_dat = DAT_CW'((pkt_len_q + LEN_W'(3)) >> 2);
  assign commit   = (state == S_GATE) && gate_ok;

  pw_credit_gate #(.HDR_CW(HDR_CW), .DAT_CW(DAT_CW)) u_gate (
    .clk(clk), .rst(rst), .hdr_limit(hdr_limit), .dat_limit(dat_limit),
    .need_dat(need_dat), .take(commit), .ok(gate_ok),
    .hdr_used(hdr_used), .dat_used(dat_used)
  );

  assign tx_free = !tx_valid || tx_ready;
  assign pf_pop  = (state == S_PAY) && tx_free && (pf_cnt != '0);

  pw_prefetch #(.DW(32), .DEPTH(PF_DEPTH)) u_pf (
    .clk(clk), .rst(rst), .push(rd_pend), .push_data(rd_data),
    .pop(pf_pop), .head(pf_head), .count(pf_cnt)
  );

  always_comb begin
    occ   = OCC_W'(pf_cnt) + OCC_W'(rd_pend);
    rd_en = ((state == S_HDR) || (state == S_PAY)) && (rd_left != '0) &&
            ((occ < OCC_W'(PF_DEPTH)) || ((occ == OCC_W'(PF_DEPTH)) && pf_pop));
  end
  assign rd_addr = src_q;
  assign busy    = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      src_q     <= '0;
      dst_q     <= '0;
      pkt_dst   <= '0;
      rem_q     <= '0;
      pkt_len_q <= '0;
      rd_left   <= '0;
      pay_left  <= '0;
      hdr_idx   <= '0;
      rd_pend   <= 1'b0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
      tx_sop    <= 1'b0;
      tx_eop    <= 1'b0;
      done      <= 1'b0;
    end else begin
      done    <= 1'b0;
      rd_pend <= rd_en;
      if (rd_en) begin
        src_q   <= src_q + LOC_AW'(1);
        rd_left <= rd_left - LEN_W'(1);
      end
      if (tx_valid && tx_ready) tx_valid <= 1'b0;

      case (state)
        S_IDLE: if (start) begin
          if (cmd_len == '0) begin
            done <= 1'b1;
          end else begin
            src_q <= cmd_src;
            dst_q <= cmd_dst[31:2];
            rem_q <= cmd_len;
            state <= S_SIZE;
          end
        end
        S_SIZE: begin
          pkt_len_q <= calc_len;
          state     <= S_GATE;
        end
        S_GATE: if (gate_ok) begin
          pkt_dst  <= dst_q;
          dst_q    <= dst_q + 30'(pkt_len_q);
          rem_q    <= rem_q - pkt_len_q;
          rd_left  <= pkt_len_q;
          pay_left <= pkt_len_q;
          hdr_idx  <= '0;
          state    <= S_HDR;
        end
        S_HDR: if (tx_free) begin
          tx_valid <= 1'b1;
          tx_data  <= hdr_word(hdr_idx, pkt_len_q[9:0], pkt_dst);
          tx_sop   <= (hdr_idx == 2'd0);
          tx_eop   <= 1'b0;
          hdr_idx  <= hdr_idx + 2'd1;
          if (hdr_idx == 2'(HDR_BEATS-1)) state <= S_PAY;
        end
        S_PAY: if (pf_pop) begin
          tx_valid <= 1'b1;
          tx_data  <= pf_head;
          tx_sop   <= 1'b0;
          tx_eop   <= (pay_left == LEN_W'(1));
          pay_left <= pay_left - LEN_W'(1);
          if (pay_left == LEN_W'(1))
            state <= (rem_q == '0) ? S_DRAIN : S_SIZE;
        end
        S_DRAIN: if (tx_valid && tx_ready && tx_eop) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int LEN_W    = 13,
  parameter int HDR_CW   = 6,
  parameter int DAT_CW   = 8,
  parameter int MAX_CODE = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [31:0]       tx_data,
  input logic              tx_sop,
  input logic              tx_eop,
  input logic              commit,
  input logic [LEN_W-1:0]  pkt_len,
  input logic [29:0]       dst_dw,
  input logic [HDR_CW-1:0] hdr_limit,
  input logic [DAT_CW-1:0] dat_limit,
  input logic [HDR_CW-1:0] hdr_used,
  input logic [DAT_CW-1:0] dat_used
);
  localparam int MAX_DW = 32 << MAX_CODE;

  logic [HDR_CW-1:0] h_av;
  logic [DAT_CW-1:0] d_av, d_need;
  logic [LEN_W:0]    page_end;
  always_comb begin
    h_av     = hdr_limit - hdr_used;
    d_av     = dat_limit - dat_used;
    d_need   = DAT_CW'((pkt_len + LEN_W'(3)) >> 2);
    page_end = (LEN_W+1)'(dst_dw[9:0]) + (LEN_W+1)'(pkt_len);
  end

  AST_GATE_HDR: assert property (@(posedge clk) disable iff (rst)
    commit |-> (h_av != '0));                                           // R6
  AST_GATE_DAT: assert property (@(posedge clk) disable iff (rst)
    commit |-> (d_av >= d_need));                                       // R6
  AST_NO_4K_CROSS: assert property (@(posedge clk) disable iff (rst)
    commit |-> (page_end <= (LEN_W+1)'(1024)));                         // R3
  AST_USED_WRAP: assert property (@(posedge clk) disable iff (rst)
    commit |=> (hdr_used == HDR_CW'($past(hdr_used) + 1'b1)));         // R8
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_sop) |-> ((tx_data[9:0] != 10'd0) &&
                              (tx_data[9:0] <= 10'(MAX_DW))));          // R1
  AST_SOP_NOT_EOP: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_sop) |-> !tx_eop);                                  // R5
  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) &&
                                 $stable(tx_sop) && $stable(tx_eop)));  // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                    // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);                                                    // R10
endmodule

bind pw_packetizer pw_checker #(
  .LEN_W(LEN_W), .HDR_CW(HDR_CW), .DAT_CW(DAT_CW), .MAX_CODE(MAX_CODE)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_sop(tx_sop), .tx_eop(tx_eop), .commit(commit),
  .pkt_len(pkt_len_q), .dst_dw(dst_q),
  .hdr_limit(hdr_limit), .dat_limit(dat_limit),
  .hdr_used(hdr_used), .dat_used(dat_used)
);

// File: tb/pw_packetizer_test.sv
module pw_packetizer_test;
  localparam int CLK_P  = 10;
  localparam int LOC_AW = 10;
  localparam int LEN_W  = 13;
  localparam int HDR_CW = 6;
  localparam int DAT_CW = 8;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [LOC_AW-1:0] cmd_src = '0;
  logic [31:0] cmd_dst = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [2:0] ctl_mps = 3'd1, cap_mps = 3'd1;
  logic [HDR_CW-1:0] hdr_limit = '0;
  logic [DAT_CW-1:0] dat_limit = '0;
  logic rd_en, tx_valid, tx_sop, tx_eop, busy, done;
  logic [LOC_AW-1:0] rd_addr;
  logic [31:0] rd_data = '0, tx_data;
  logic tx_ready = 1'b1;

  pw_packetizer uut (.*);

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] memf(input int a);
    return 32'hC0DE0000 ^ (32'(a % 1024) * 32'h00010003);
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= memf(int'(rd_addr));

  int nchk = 0, nerr = 0, cyc = 0, beats = 0, dones = 0, sops = 0;
  int rmode = 0, cmode = 0;
  logic done_due = 1'b0, zl_arm = 1'b0;
  logic [HDR_CW-1:0] m_hu = '0;
  logic [DAT_CW-1:0] m_du = '0;
  logic [34:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic build(input int src, input int dst, input int len);
    int eff, mps, rem, d, s, n;
    eff = (ctl_mps < cap_mps) ? ctl_mps : cap_mps;
    if (eff > 1) eff = 1;
    mps = 32 << eff;
    rem = len; d = dst; s = src;
    while (rem > 0) begin
      n = rem;
      if (n > mps) n = mps;
      if (n > 1024 - ((d >> 2) % 1024)) n = 1024 - ((d >> 2) % 1024);
      exp_q.push_back({1'b0, 1'b1, 1'b0, 8'h40, 14'h0, 10'(n)});
      exp_q.push_back({3'b000, 24'h0, (n == 1) ? 4'h0 : 4'hF, 4'hF});
      exp_q.push_back({3'b000, 32'(d)});
      for (int i = 0; i < n; i++)
        exp_q.push_back({(rem == n) && (i == n-1), 1'b0, i == n-1, memf(s + i)});
      rem -= n; d += 4 * n; s += n;
    end
  endtask

  // reference comparison on every clock, away from the active edge
  always @(negedge clk) if (!rst) begin
    logic [34:0] e;
    int need;
    cyc++;
    chk(done === done_due, "R10 done timing", done, done_due);
    if (done) dones++;
    done_due = zl_arm; zl_arm = 1'b0;
    tx_ready = (rmode == 0) ? 1'b1 : (($urandom % 4) != 0);
    if (tx_valid && tx_ready) begin
      beats++;
      if (exp_q.size() == 0) chk(0, "R11 unexpected beat", tx_data, 0);
      else begin
        e = exp_q.pop_front();
        chk(tx_data === e[31:0], e[33] ? "R1 R4 header length" : "R4 R5 data", tx_data, e[31:0]);
        chk({tx_sop, tx_eop} === e[33:32], "R5 sop/eop", {tx_sop, tx_eop}, e[33:32]);
        if (tx_sop) begin
          sops++;
          need = (int'(tx_data[9:0]) + 3) / 4;
          chk(HDR_CW'(hdr_limit - m_hu) >= 1, "R6 header credit", HDR_CW'(hdr_limit - m_hu), 1);
          chk(int'(DAT_CW'(dat_limit - m_du)) >= need, "R6 data credit", DAT_CW'(dat_limit - m_du), need);
          m_hu = m_hu + 1'b1;
          m_du = m_du + DAT_CW'(need);
        end
        if (e[34]) done_due = 1'b1;
      end
    end
    if (cmode == 0) begin hdr_limit = m_hu + 6'd8; dat_limit = m_du + 8'd100; end
    else if (cmode == 2) begin hdr_limit = m_hu + 6'd1; dat_limit = m_du + 8'd16; end
    if (cyc > 150000) begin
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  task automatic kick(input int src, input int dst, input int len, input bit build_exp);
    @(posedge clk); #1;
    if (build_exp) build(src, dst, len);
    cmd_src = LOC_AW'(src); cmd_dst = 32'(dst); cmd_len = LEN_W'(len);
    start = 1'b1;
    if (len == 0) zl_arm = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(input int target);
    while (dones < target) @(posedge clk);
    repeat (3) @(posedge clk);
    chk(exp_q.size() == 0, "R10 all beats delivered", exp_q.size(), 0);
  endtask

  int b0, d0;
  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0, "R10 reset busy", busy, 0);
    chk(tx_valid === 1'b0, "R10 reset valid", tx_valid, 0);
    chk(done === 1'b0, "R10 reset done", done, 0);

    // R1 R4 R5: 256-byte packets, split 64 + 36
    kick(0, 32'h1000, 100, 1); wait_done(1);
    chk(sops == 2, "R1 packet count", sops, 2);

    // R2: capability below control code -> 128-byte packets, random backpressure (R9)
    rmode = 1; ctl_mps = 3'd2; cap_mps = 3'd0;
    kick(100, 32'h3000, 70, 1); wait_done(2);
    chk(sops == 5, "R2 cap clamp packets", sops, 5);

    // R2: both codes above the supported maximum -> 64 dwords
    ctl_mps = 3'd3; cap_mps = 3'd5;
    kick(5, 32'h5000, 130, 1); wait_done(3);
    chk(sops == 8, "R2 design max packets", sops, 8);

    // R3: 4 KB boundary split 4 + 6
    ctl_mps = 3'd1; cap_mps = 3'd1; rmode = 0;
    kick(200, 32'h6FF0, 10, 1); wait_done(4);
    chk(sops == 10, "R3 boundary split", sops, 10);

    // R4: single-dword packet, last byte enables zero
    kick(7, 32'h7004, 1, 1); wait_done(5);

    // R11: zero-length start
    b0 = beats;
    kick(0, 32'h8000, 0, 0); wait_done(6);
    chk(beats == b0, "R11 zero length no beats", beats - b0, 0);

    // R11: start while busy ignored
    kick(300, 32'h9000, 150, 1);
    repeat (10) @(posedge clk);
    kick(0, 32'hA000, 20, 0);
    wait_done(7);
    repeat (20) @(posedge clk);
    chk(dones == 7, "R11 busy start ignored", dones, 7);

    // R7: credit stall at exact boundaries
    @(posedge clk); #1;
    cmode = 1; hdr_limit = m_hu; dat_limit = m_du;
    b0 = beats; d0 = dones;
    kick(400, 32'hB000, 40, 1);
    repeat (30) @(posedge clk);
    chk(beats == b0, "R7 no header credit stall", beats - b0, 0);
    chk(busy === 1'b1, "R7 busy while stalled", busy, 1);
    #1 hdr_limit = m_hu + 1'b1; dat_limit = m_du + 8'd9;
    repeat (30) @(posedge clk);
    chk(beats == b0, "R7 one data credit short stall", beats - b0, 0);
    #1 dat_limit = m_du + 8'd10;
    wait_done(d0 + 1);
    chk(beats == b0 + 43, "R7 resumed after limit raise", beats - b0, 43);

    // R8: tight credits over 64 full packets wrap both counters
    cmode = 2; rmode = 1; d0 = sops;
    kick(0, 32'h20000, 4096, 1); wait_done(9);
    chk(sops - d0 == 64, "R8 wrap packet count", sops - d0, 64);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule